// File: doc/BRIEF.md
# Serial EEPROM Line Adapter for a CPU Bus

This block sits between a CPU's byte or word accesses and the two wires of a serial EEPROM engine. A CPU write carries the clock line, the data line, or both, depending on which half of an address pair it targets. Configuration inputs choose that mapping: which address parity feeds each line, and which data bit carries the clock, the incoming data and the returned data.

The adapter does not pass writes straight through. It holds the most recent clock and data levels as pending values and moves them onto the committed lines only when the timing allows. A free-running cycle counter and a timestamp of the last real line change set that timing. Writes that arrive in quick succession merge into one pending update. A read flushes the pending levels first and then returns a single bit. The bit comes from the engine when the engine drives the line; otherwise the pending data level is returned as open bus. A read also tells the engine whether it should be treated as belonging to the next clock period.

The engine that follows the EEPROM protocol is outside this block. It sees the committed lines, a one-cycle change strobe and a read query, and it answers the query in the same cycle.

Top module: `eep_pin_adapter`

## Requirements
- R1: After reset the committed clock and data lines are both 1, the pending levels are both 1, no change strobe, read valid or read data is active, and the timestamp starts 65536 cycles behind the counter. As a result, the first accesses after reset count as far apart from any earlier change.
- R2: A write updates the pending clock from `wdata[cfg_bit_cl]` when `addr_odd` equals `cfg_abits[0]`. It updates the pending data level from `wdata[cfg_bit_in]` when `addr_odd` equals `cfg_abits[1]`. When both match, both are updated. When neither matches, the pending levels stay unchanged.
- R3: `core_scl` and `core_sda` change only together with a one-cycle `core_commit` pulse. The pulse appears in the cycle after the access that caused it, and the new levels are visible in that same cycle.
- R4: A write whose interval is below 16 updates only the pending levels and commits nothing. The interval is the cycle counter minus the timestamp, taken modulo 2^32.
- R5: A write whose interval is 16 or more first copies the previous pending levels to the committed lines and then stores its own levels as pending. `core_commit` fires, and the timestamp takes the current count, only if a committed level actually changed.
- R6: A read copies the pending levels to the committed lines whatever the interval, under the same change and timestamp rule as R5. In the next cycle the read raises `rd_valid` and `core_rd_req`.
- R7: `core_rd_early` is 1 with the read query when the pending clock was 0 at the read and the interval, measured before the read's own commit, was 24 or more. Otherwise it is 0.
- R8: While `rd_valid` is high, `rdata` holds one bit at position `cfg_bit_out` and all other bits are 0. That bit is `core_bit` when `core_drive` is 1; otherwise it is the pending data level at the time of the read.
- R9: When `wr_en` and `rd_en` are high in the same cycle, the write is carried out and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also advances the cycle counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per access |
| rd_en | input | 1 | CPU read strobe, one cycle per access |
| addr_odd | input | 1 | Address bit 0 of the access |
| wdata | input | DATA_W | Write data |
| cfg_abits | input | 2 | Bit 0: parity carrying the clock; bit 1: parity carrying data-in |
| cfg_bit_cl | input | SEL_W | Data bit index that holds the clock level |
| cfg_bit_in | input | SEL_W | Data bit index that holds the data-in level |
| cfg_bit_out | input | SEL_W | Data bit index where the returned bit is placed |
| core_drive | input | 1 | Engine drives the data line during the query |
| core_bit | input | 1 | Engine's data bit during the query |
| core_scl | output | 1 | Committed clock line |
| core_sda | output | 1 | Committed data line |
| core_commit | output | 1 | One-cycle strobe: committed lines just changed |
| core_rd_req | output | 1 | Read query to the engine |
| core_rd_early | output | 1 | Query belongs to the next clock period |
| rd_valid | output | 1 | Read data valid |
| rdata | output | DATA_W | Read data, a single bit at cfg_bit_out |

## Verification
The bench runs writes that are spaced below the 16-cycle window, exactly at it and well beyond it. This separates a merged pending update from a real commit, and a commit that changes a line from one that does not. One sequence follows a no-change commit with a changing write and then a third write a few cycles later. That sequence is the only one that shows whether the timestamp was refreshed wrongly. Reads alternate between a driving and an idle engine, with the pending clock low and high. This separates open-bus data from engine data and an early query from an ordinary one. Three mapping configurations, including one where both lines share a parity and one where a write matches no lane, show that the bit and parity selection is not fixed.

// File: rtl/eep_adapt_pkg.sv
package eep_adapt_pkg;

    // one pair of serial line levels
    typedef struct packed {
        logic scl;
        logic sda;
    } eep_lines_t;

    localparam eep_lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};

endpackage

// File: rtl/eep_lane_pick.sv
module eep_lane_pick
    import eep_adapt_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int SEL_W  = $clog2(DATA_W)
) (
    input  logic              addr_odd,
    input  logic [1:0]        cfg_abits,
    input  logic [SEL_W-1:0]  sel_cl,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [DATA_W-1:0] wdata,
    input  eep_lines_t        cur,
    output eep_lines_t        nxt
);

    // parity match selects the lane, bit index selects the level
    always_comb begin
        nxt = cur;
        if (addr_odd == cfg_abits[0]) nxt.scl = wdata[sel_cl];
        if (addr_odd == cfg_abits[1]) nxt.sda = wdata[sel_in];
    end

endmodule

// File: rtl/eep_gap_meter.sv
module eep_gap_meter #(
    parameter int          CNT_W      = 32,
    parameter int          MIN_GAP    = 16,
    parameter int          EARLY_GAP  = 24,
    parameter logic [63:0] STAMP_INIT = 64'hFFFF_0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stamp,
    output logic short_gap,
    output logic long_gap
);

    localparam logic [CNT_W-1:0] STAMP_RST = STAMP_INIT[CNT_W-1:0];
    localparam logic [CNT_W-1:0] MIN_LIM   = CNT_W'(MIN_GAP);
    localparam logic [CNT_W-1:0] EARLY_LIM = CNT_W'(EARLY_GAP);

    typedef struct packed {
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] last;
    } gap_st_t;

    gap_st_t st_d, st_q;
    logic [CNT_W-1:0] span;

    always_comb begin
        st_d      = st_q;
        st_d.cyc  = st_q.cyc + 1'b1;
        if (stamp) st_d.last = st_q.cyc;
        span      = st_q.cyc - st_q.last;
        short_gap = (span < MIN_LIM);
        long_gap  = (span >= EARLY_LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cyc  <= '0;
            st_q.last <= STAMP_RST;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GAP_CLASSES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (EARLY_GAP >= MIN_GAP && short_gap) |-> !long_gap); // R4

endmodule

// File: rtl/eep_read_pack.sv
module eep_read_pack #(
    parameter  int DATA_W = 16,
    localparam int SEL_W  = $clog2(DATA_W)
) (
    input  logic              en,
    input  logic              bit_val,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] rdata
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign rdata[i] = en && bit_val && (sel == SEL_W'(i));
    end

endmodule

// File: rtl/eep_pin_adapter.sv
module eep_pin_adapter
    import eep_adapt_pkg::*;
#(
    parameter  int          DATA_W     = 16,
    parameter  int          CNT_W      = 32,
    parameter  int          MIN_GAP    = 16,
    parameter  int          EARLY_GAP  = 24,
    parameter  logic [63:0] STAMP_INIT = 64'hFFFF_0000,
    localparam int          SEL_W      = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr_odd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        cfg_abits,
    input  logic [SEL_W-1:0]  cfg_bit_cl,
    input  logic [SEL_W-1:0]  cfg_bit_in,
    input  logic [SEL_W-1:0]  cfg_bit_out,
    input  logic              core_drive,
    input  logic              core_bit,
    output logic              core_scl,
    output logic              core_sda,
    output logic              core_commit,
    output logic              core_rd_req,
    output logic              core_rd_early,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        eep_lines_t pend;
        eep_lines_t com;
        logic       commit;
        logic       rd_req;
        logic       early;
        logic       open_sda;
    } adp_st_t;

    adp_st_t    st_d, st_q;
    eep_lines_t lane_nxt;
    logic       short_gap, long_gap, stamp;
    logic       flush_diff;

    eep_lane_pick #(.DATA_W(DATA_W)) u_lane (
        .addr_odd  (addr_odd),
        .cfg_abits (cfg_abits),
        .sel_cl    (cfg_bit_cl),
        .sel_in    (cfg_bit_in),
        .wdata     (wdata),
        .cur       (st_q.pend),
        .nxt       (lane_nxt)
    );

    eep_gap_meter #(
        .CNT_W      (CNT_W),
        .MIN_GAP    (MIN_GAP),
        .EARLY_GAP  (EARLY_GAP),
        .STAMP_INIT (STAMP_INIT)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .stamp     (stamp),
        .short_gap (short_gap),
        .long_gap  (long_gap)
    );

    // next-state: write path wins over read path
    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        st_d.rd_req = 1'b0;
        st_d.early  = 1'b0;
        stamp       = 1'b0;
        flush_diff  = (st_q.pend != st_q.com);
        if (wr_en) begin
            if (!short_gap) begin
                st_d.com    = st_q.pend;
                st_d.commit = flush_diff;
                stamp       = flush_diff;
            end
            st_d.pend = lane_nxt;
        end else if (rd_en) begin
            st_d.com      = st_q.pend;
            st_d.commit   = flush_diff;
            stamp         = flush_diff;
            st_d.rd_req   = 1'b1;
            st_d.early    = !st_q.pend.scl && long_gap;
            st_d.open_sda = st_q.pend.sda;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend     <= LINES_IDLE;
            st_q.com      <= LINES_IDLE;
            st_q.commit   <= 1'b0;
            st_q.rd_req   <= 1'b0;
            st_q.early    <= 1'b0;
            st_q.open_sda <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    eep_read_pack #(.DATA_W(DATA_W)) u_pack (
        .en      (st_q.rd_req),
        .bit_val (core_drive ? core_bit : st_q.open_sda),
        .sel     (cfg_bit_out),
        .rdata   (rdata)
    );

    assign core_scl      = st_q.com.scl;
    assign core_sda      = st_q.com.sda;
    assign core_commit   = st_q.commit;
    assign core_rd_req   = st_q.rd_req;
    assign core_rd_early = st_q.early;
    assign rd_valid      = st_q.rd_req;

    AST_COMMIT_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        core_commit |-> (core_scl != $past(core_scl)) || (core_sda != $past(core_sda))); // R5
    AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !core_commit |-> $stable(core_scl) && $stable(core_sda)); // R3
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd_en && !wr_en) |-> rd_valid); // R6
    AST_WRITE_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd_en && wr_en) |-> !rd_valid); // R9
    AST_EARLY_WITH_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
        core_rd_early |-> core_rd_req); // R7
    AST_READ_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $countones(rdata) <= 1); // R8

endmodule

// File: tb/eep_pin_adapter_bench.sv
module eep_pin_adapter_bench;

    localparam int DW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, addr_odd = 1'b0;
    logic [15:0] wdata = '0;
    logic [1:0]  cfg_abits = 2'b10;
    logic [3:0]  cfg_bit_cl = 4'd1, cfg_bit_in = 4'd0, cfg_bit_out = 4'd0;
    logic        core_drive = 1'b0, core_bit = 1'b0;
    logic        core_scl, core_sda, core_commit, core_rd_req, core_rd_early, rd_valid;
    logic [15:0] rdata;

    eep_pin_adapter u_eep_pin_adapter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr_odd(addr_odd),
        .wdata(wdata), .cfg_abits(cfg_abits), .cfg_bit_cl(cfg_bit_cl),
        .cfg_bit_in(cfg_bit_in), .cfg_bit_out(cfg_bit_out), .core_drive(core_drive),
        .core_bit(core_bit), .core_scl(core_scl), .core_sda(core_sda),
        .core_commit(core_commit), .core_rd_req(core_rd_req),
        .core_rd_early(core_rd_early), .rd_valid(rd_valid), .rdata(rdata)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [31:0] n = '0;
    always @(posedge clk) if (rst_n) n <= n + 1;

    // reference state
    logic [1:0]  m_pend = 2'b11, m_com = 2'b11;
    logic [31:0] m_last = 32'hFFFF_0000;

    // scoreboard queues
    bit          e_rd[$];
    logic [1:0]  e_lines[$];
    logic [15:0] e_data[$];
    bit          e_early[$];
    logic [31:0] e_due[$];
    string       e_tag[$];

    task automatic push(bit rd, logic [1:0] ln, logic [15:0] dt, bit er, string tg);
        e_rd.push_back(rd); e_lines.push_back(ln); e_data.push_back(dt);
        e_early.push_back(er); e_due.push_back(n + 1); e_tag.push_back(tg);
    endtask

    task automatic pop();
        void'(e_rd.pop_front()); void'(e_lines.pop_front()); void'(e_data.pop_front());
        void'(e_early.pop_front()); void'(e_due.pop_front()); void'(e_tag.pop_front());
    endtask

    task automatic check(bit ok, string tg, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", tg, act, exp, n);
        end
    endtask

    task automatic model_write(logic a, logic [15:0] d, string tg);
        logic [31:0] iv = n - m_last;
        if (iv >= 32'd16) begin
            if (m_pend != m_com) begin
                push(1'b0, m_pend, '0, 1'b0, tg);
                m_last = n;
            end
            m_com = m_pend;
        end
        if (a == cfg_abits[0]) m_pend[1] = d[cfg_bit_cl];
        if (a == cfg_abits[1]) m_pend[0] = d[cfg_bit_in];
    endtask

    task automatic model_read(string tg);
        logic [31:0] iv = n - m_last;
        bit er = !m_pend[1] && (iv >= 32'd24);
        logic bv = core_drive ? core_bit : m_pend[0];
        if (m_pend != m_com) begin
            push(1'b0, m_pend, '0, 1'b0, "R6");
            m_last = n;
        end
        m_com = m_pend;
        push(1'b1, 2'b00, 16'(bv) << cfg_bit_out, er, tg);
    endtask

    task automatic op(logic w, logic r, logic a, logic [15:0] d, string tg);
        @(negedge clk); #1;
        if (w) model_write(a, d, tg);
        else if (r) model_read(tg);
        wr_en = w; rd_en = r; addr_odd = a; wdata = d;
        @(negedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    // monitor: compares design outputs with queued expectations
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (e_due.size() > 0 && e_due[0] < n) begin
                check(1'b0, {e_tag[0], " missing event"}, 0, 1);
                pop();
            end
            if (core_commit) begin
                if (e_rd.size() == 0 || e_rd[0]) check(1'b0, "R3 unexpected commit", 1, 0);
                else begin
                    check({core_scl, core_sda} == e_lines[0], {e_tag[0], " commit lines"},
                          {core_scl, core_sda}, e_lines[0]);
                    pop();
                end
            end
            if (rd_valid) begin
                if (e_rd.size() == 0 || !e_rd[0]) check(1'b0, "R9 unexpected read", 1, 0);
                else begin
                    check(rdata == e_data[0], {e_tag[0], " R8 read data"}, rdata, e_data[0]);
                    check(core_rd_early == e_early[0], {e_tag[0], " R7 early flag"},
                          core_rd_early, e_early[0]);
                    check(core_rd_req, "R6 query", core_rd_req, 1);
                    pop();
                end
            end
        end
    end

    function automatic logic [31:0] step(logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        logic [31:0] seed = 32'h1357_9BDF;
        idle(3);
        // R1 reset state
        check(core_scl && core_sda, "R1 lines idle", {core_scl, core_sda}, 2'b11);
        check(!core_commit && !rd_valid && rdata == 0, "R1 quiet outputs",
              {core_commit, rd_valid, rdata}, 0);
        rst_n = 1'b1;

        // config A: clock on even, data on odd, clock bit 1, data bit 0
        op(1, 0, 0, 16'h0000, "R2");            // pending clock low
        core_drive = 0;
        op(0, 1, 0, 16'h0000, "R1 R7");          // early read, open bus = 1
        op(1, 0, 1, 16'h0000, "R4");             // short: pending data low
        op(1, 0, 0, 16'h0002, "R4");             // short: pending clock high
        idle(20); op(1, 0, 1, 16'h0001, "R5");   // commits (1,0)
        idle(20); op(1, 0, 1, 16'h0001, "R5");   // commits (1,1)
        idle(20); op(1, 0, 1, 16'h0001, "R5");   // no change, no stamp
        op(1, 0, 0, 16'h0000, "R5");             // pending clock low
        op(1, 0, 0, 16'h0000, "R5");             // must commit (0,1)
        core_drive = 1; core_bit = 0;
        op(0, 1, 0, 16'h0000, "R8");             // engine drives 0
        idle(20); op(1, 1, 1, 16'h0000, "R9");   // write wins, no read

        // config B: both lanes on even, clock bit 6, data bit 7, output bit 7
        idle(20);
        cfg_abits = 2'b00; cfg_bit_cl = 4'd6; cfg_bit_in = 4'd7; cfg_bit_out = 4'd7;
        op(1, 0, 1, 16'h00C0, "R2");             // no lane matches
        idle(20); op(1, 0, 0, 16'h0080, "R2");   // clock 0, data 1 together
        core_drive = 0;
        idle(30); op(0, 1, 0, 16'h0000, "R8");

        // randomized mixes over three mappings
        for (int i = 0; i < 240; i++) begin
            seed = step(seed);
            if (i == 80) begin
                cfg_abits = 2'b01; cfg_bit_cl = 4'd0; cfg_bit_in = 4'd15; cfg_bit_out = 4'd3;
            end
            if (i == 160) begin
                cfg_abits = 2'b10; cfg_bit_cl = 4'd1; cfg_bit_in = 4'd0; cfg_bit_out = 4'd0;
            end
            idle(int'(seed[4:0]) % 31);
            core_drive = seed[10]; core_bit = seed[11];
            case (seed[8:7])
                2'd0, 2'd1: op(1, 0, seed[9], seed[31:16], "R5");
                2'd2:       op(0, 1, seed[9], seed[31:16], "R8");
                default:    op(1, 1, seed[9], seed[31:16], "R9");
            endcase
        end

        idle(5);
        check(e_rd.size() == 0, "R3 all events seen", e_rd.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule